// File: doc/BRIEF.md
# Dual-Unit Dynamic Issue Scheduler

This block is the timing core of an out-of-order issue stage. An in-order stream of instructions enters one at a time. Each instruction carries an operation (add, subtract, multiply or divide), a destination tag and two source tags. The scheduler places each instruction in a waiting slot of its class: adds and subtracts in one pool, multiplies and divides in another. It holds an instruction there until both operands have been produced. It then starts the instruction on that class's single execution unit, counts out the fixed latency, and puts the finished tag on one shared result bus. No operand values are computed. The block only decides in which cycle each event happens.

A tag scoreboard records which destination tags are still in flight. A source operand that is not in flight at issue counts as available. Waiting slots snoop the result bus and mark an operand as available when its tag is broadcast. Each cycle, three kinds of event are reported, each with the sequence number the scheduler gave the instruction at issue: an issue, an execution start per unit, and a writeback. A testbench or performance model can compare these events against a timing table.

Top module: `tomasulo_sched`

## Requirements
- R1: Instructions issue in arrival order, at most one per cycle, and each issue receives the next sequence number. The first issue after reset is numbered 1. When the pool for the head instruction's class is full, `in_ready` is low, nothing issues, and younger instructions of either class wait behind it.
- R2: By default the add/subtract pool has three slots and the multiply/divide pool has two. A slot becomes free at the end of the cycle in which its instruction broadcasts. An instruction can issue into that slot in the next cycle at the earliest.
- R3: An instruction never starts execution in the cycle it issues. The earliest start is the following cycle.
- R4: A source tag of 0, or a tag that is not in flight, is available at issue. A tag broadcast in the issue cycle also counts as available. Otherwise the consumer starts no earlier than the cycle after the producer's broadcast.
- R5: Execution latencies are 2 cycles for add and subtract, 4 for multiply and 8 for divide. The result is broadcast in the last execution cycle if the bus is free.
- R6: The two units work in parallel, and each runs one instruction at a time. A unit accepts a new start in the cycle after its current instruction broadcasts.
- R7: There is one result bus. When both units finish in the same cycle, the add/subtract result goes first. The multiply/divide result goes in the next cycle, and that instruction keeps its slot and its unit until then.
- R8: When several slots of one class are ready while their unit is idle, the one issued earliest starts first.
- R9: After reset all slots are empty, `in_ready` is high, no start or writeback is reported, and `iss_idx` is 1.
- R10: `in_op` is encoded as 0 add, 1 subtract, 2 multiply, 3 divide, and bit 1 selects the multiply/divide class. `wb_tag` carries the destination tag of the instruction being written back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Head instruction present |
| in_op | input | 2 | Operation: 0 add, 1 sub, 2 mul, 3 div |
| in_dst | input | 4 | Destination tag (nonzero) |
| in_src_a | input | 4 | First source tag, 0 when none |
| in_src_b | input | 4 | Second source tag, 0 when none |
| in_ready | output | 1 | A slot is free for the head instruction's class |
| iss_valid | output | 1 | Head instruction issues this cycle |
| iss_idx | output | 8 | Sequence number given to the issuing instruction |
| as_start | output | 1 | Add/subtract unit starts an instruction |
| as_start_idx | output | 8 | Sequence number of that instruction |
| md_start | output | 1 | Multiply/divide unit starts an instruction |
| md_start_idx | output | 8 | Sequence number of that instruction |
| wb_valid | output | 1 | A result is on the bus |
| wb_idx | output | 8 | Sequence number of the broadcasting instruction |
| wb_tag | output | 4 | Destination tag being broadcast |

## Verification
The assertions take for granted that the feeder never uses tag 0 as a destination. They also assume that no destination tag is reused while an earlier producer of that tag is still in flight. Under that assumption every broadcast tag is marked pending in the scoreboard. The stimulus programs give each instruction a distinct destination tag between 1 and 10, so every in-flight tag is unique. Each program runs from a fresh reset. Each program has fewer than 2^7 instructions, so the modular age comparison stays valid.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int TAG_W = 4;
    localparam int IDX_W = 8;
    localparam int NTAG  = 1 << TAG_W;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_DIV = 2'd3
    } op_e;

    // one waiting slot; long_op is op bit 0 (sub/div pick the second latency)
    typedef struct packed {
        logic             long_op;
        logic [TAG_W-1:0] dst;
        logic [TAG_W-1:0] src_a;
        logic [TAG_W-1:0] src_b;
        logic             rdy_a;
        logic             rdy_b;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // a issued before b, modulo sequence wrap
    function automatic logic older(input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
        logic [IDX_W-1:0] d;
        d = a - b;
        return d[IDX_W-1];
    endfunction

endpackage

// File: rtl/rs_pool.sv
module rs_pool
    import sched_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc,
    input  slot_t            alloc_data,
    input  logic             bc_valid,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic             unit_free,
    input  logic             release_en,
    input  logic [SW-1:0]    release_slot,
    output logic             has_free,
    output logic             start,
    output logic [SW-1:0]    start_slot,
    output logic             start_long,
    output logic [TAG_W-1:0] start_dst,
    output logic [IDX_W-1:0] start_idx
);

    logic [DEPTH-1:0] valid_v;
    logic [DEPTH-1:0] ready_v;
    slot_t            ent_v [DEPTH];
    logic [SW-1:0]    free_slot;
    logic [SW-1:0]    pick_slot;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_found;

    // lowest empty slot receives the next allocation
    always_comb begin
        has_free  = 1'b0;
        free_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_v[i]) begin
                has_free  = 1'b1;
                free_slot = SW'(i);
            end
        end
    end

    // oldest ready slot wins the unit
    always_comb begin
        pick_found = 1'b0;
        pick_slot  = '0;
        pick_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ready_v[i] && (!pick_found || older(ent_v[i].idx, pick_idx))) begin
                pick_found = 1'b1;
                pick_slot  = SW'(i);
                pick_idx   = ent_v[i].idx;
            end
        end
    end

    assign start      = pick_found && unit_free;
    assign start_slot = pick_slot;
    assign start_long = ent_v[pick_slot].long_op;
    assign start_dst  = ent_v[pick_slot].dst;
    assign start_idx  = pick_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic  vq;
        logic  rq;
        slot_t eq;

        always_ff @(posedge clk) begin
            if (rst) begin
                vq <= 1'b0;
                rq <= 1'b0;
                eq <= '0;
            end else if (alloc && free_slot == SW'(g)) begin
                vq <= 1'b1;
                rq <= 1'b0;
                eq <= alloc_data;
            end else if (release_en && release_slot == SW'(g)) begin
                vq <= 1'b0;
                rq <= 1'b0;
            end else begin
                if (start && start_slot == SW'(g)) rq <= 1'b1;
                if (bc_valid && eq.src_a == bc_tag) eq.rdy_a <= 1'b1;
                if (bc_valid && eq.src_b == bc_tag) eq.rdy_b <= 1'b1;
            end
        end

        assign valid_v[g] = vq;
        assign ready_v[g] = vq && !rq && eq.rdy_a && eq.rdy_b;
        assign ent_v[g]   = eq;

        // R2
        release_started_chk: assert property (@(posedge clk) disable iff (rst)
            (release_en && release_slot == SW'(g)) |-> (vq && rq));
    end

endmodule

// File: rtl/fu_timer.sv
module fu_timer
    import sched_pkg::*;
#(
    parameter int LAT_LO = 2,
    parameter int LAT_HI = 2,
    parameter int SW = 1,
    localparam int LMAX = (LAT_LO > LAT_HI) ? LAT_LO : LAT_HI,
    localparam int CW = $clog2(LMAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_long,
    input  logic [SW-1:0]    start_slot,
    input  logic [TAG_W-1:0] start_dst,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             grant,
    output logic             busy,
    output logic             want,
    output logic [SW-1:0]    cur_slot,
    output logic [TAG_W-1:0] cur_dst,
    output logic [IDX_W-1:0] cur_idx
);

    logic          busy_q;
    logic [CW-1:0] rem_q;
    logic [SW-1:0] slot_q;
    logic [TAG_W-1:0] dst_q;
    logic [IDX_W-1:0] idx_q;

    // rem_q counts execution cycles still to come, the current one included;
    // the start cycle itself is the first execution cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            slot_q <= '0;
            dst_q  <= '0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rem_q  <= start_long ? CW'(LAT_HI - 1) : CW'(LAT_LO - 1);
            slot_q <= start_slot;
            dst_q  <= start_dst;
            idx_q  <= start_idx;
        end else if (grant) begin
            busy_q <= 1'b0;
        end else if (busy_q && rem_q > CW'(1)) begin
            rem_q <= rem_q - CW'(1);
        end
    end

    assign busy     = busy_q;
    assign want     = busy_q && rem_q == CW'(1);
    assign cur_slot = slot_q;
    assign cur_dst  = dst_q;
    assign cur_idx  = idx_q;

    // R6
    unit_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (want && !grant) |=> (want && $stable(cur_idx)));

    // R5
    finish_release_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> !busy_q);

endmodule

// File: rtl/tomasulo_sched.sv
module tomasulo_sched
    import sched_pkg::*;
#(
    parameter int AS_DEPTH = 3,
    parameter int MD_DEPTH = 2,
    parameter int ADD_LAT  = 2,
    parameter int SUB_LAT  = 2,
    parameter int MUL_LAT  = 4,
    parameter int DIV_LAT  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [TAG_W-1:0] in_dst,
    input  logic [TAG_W-1:0] in_src_a,
    input  logic [TAG_W-1:0] in_src_b,
    output logic             in_ready,
    output logic             iss_valid,
    output logic [IDX_W-1:0] iss_idx,
    output logic             as_start,
    output logic [IDX_W-1:0] as_start_idx,
    output logic             md_start,
    output logic [IDX_W-1:0] md_start_idx,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_idx,
    output logic [TAG_W-1:0] wb_tag
);

    localparam int AS_SW = (AS_DEPTH > 1) ? $clog2(AS_DEPTH) : 1;
    localparam int MD_SW = (MD_DEPTH > 1) ? $clog2(MD_DEPTH) : 1;

    logic [NTAG-1:0]  pend_q;
    logic [IDX_W-1:0] seq_q;
    logic             in_is_md;
    slot_t            new_slot;

    logic             as_free, md_free;
    logic             as_busy, md_busy;
    logic             as_want, md_want;
    logic             as_grant, md_grant;
    logic             as_long, md_long;
    logic [AS_SW-1:0] as_sslot, as_cslot;
    logic [MD_SW-1:0] md_sslot, md_cslot;
    logic [TAG_W-1:0] as_sdst, md_sdst, as_cdst, md_cdst;
    logic [IDX_W-1:0] as_cidx, md_cidx;

    function automatic logic src_ok(input logic [TAG_W-1:0] t,
                                    input logic [NTAG-1:0] pend,
                                    input logic bv, input logic [TAG_W-1:0] bt);
        return (t == '0) || !pend[t] || (bv && bt == t);
    endfunction

    // ---------------- issue ----------------
    assign in_is_md  = in_op[1];
    assign in_ready  = in_is_md ? md_free : as_free;
    assign iss_valid = in_valid && in_ready;
    assign iss_idx   = seq_q;

    always_comb begin
        new_slot.long_op = in_op[0];
        new_slot.dst     = in_dst;
        new_slot.src_a   = in_src_a;
        new_slot.src_b   = in_src_b;
        new_slot.rdy_a   = src_ok(in_src_a, pend_q, wb_valid, wb_tag);
        new_slot.rdy_b   = src_ok(in_src_b, pend_q, wb_valid, wb_tag);
        new_slot.idx     = seq_q;
    end

    // ---------------- result bus: add/sub wins ties ----------------
    assign as_grant = as_want;
    assign md_grant = md_want && !as_want;
    assign wb_valid = as_want || md_want;
    assign wb_idx   = as_want ? as_cidx : md_cidx;
    assign wb_tag   = as_want ? as_cdst : md_cdst;

    // ---------------- tag scoreboard and sequence counter ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            seq_q  <= IDX_W'(1);
        end else begin
            if (wb_valid) pend_q[wb_tag] <= 1'b0;
            if (iss_valid) begin
                pend_q[in_dst] <= 1'b1;
                seq_q          <= seq_q + IDX_W'(1);
            end
        end
    end

    // ---------------- add/subtract class ----------------
    rs_pool #(.DEPTH(AS_DEPTH)) u_as_pool (
        .clk(clk), .rst(rst),
        .alloc(iss_valid && !in_is_md), .alloc_data(new_slot),
        .bc_valid(wb_valid), .bc_tag(wb_tag),
        .unit_free(!as_busy),
        .release_en(as_grant), .release_slot(as_cslot),
        .has_free(as_free),
        .start(as_start), .start_slot(as_sslot), .start_long(as_long),
        .start_dst(as_sdst), .start_idx(as_start_idx)
    );

    fu_timer #(.LAT_LO(ADD_LAT), .LAT_HI(SUB_LAT), .SW(AS_SW)) u_as_unit (
        .clk(clk), .rst(rst),
        .start(as_start), .start_long(as_long), .start_slot(as_sslot),
        .start_dst(as_sdst), .start_idx(as_start_idx),
        .grant(as_grant),
        .busy(as_busy), .want(as_want),
        .cur_slot(as_cslot), .cur_dst(as_cdst), .cur_idx(as_cidx)
    );

    // ---------------- multiply/divide class ----------------
    rs_pool #(.DEPTH(MD_DEPTH)) u_md_pool (
        .clk(clk), .rst(rst),
        .alloc(iss_valid && in_is_md), .alloc_data(new_slot),
        .bc_valid(wb_valid), .bc_tag(wb_tag),
        .unit_free(!md_busy),
        .release_en(md_grant), .release_slot(md_cslot),
        .has_free(md_free),
        .start(md_start), .start_slot(md_sslot), .start_long(md_long),
        .start_dst(md_sdst), .start_idx(md_start_idx)
    );

    fu_timer #(.LAT_LO(MUL_LAT), .LAT_HI(DIV_LAT), .SW(MD_SW)) u_md_unit (
        .clk(clk), .rst(rst),
        .start(md_start), .start_long(md_long), .start_slot(md_sslot),
        .start_dst(md_sdst), .start_idx(md_start_idx),
        .grant(md_grant),
        .busy(md_busy), .want(md_want),
        .cur_slot(md_cslot), .cur_dst(md_cdst), .cur_idx(md_cidx)
    );

    // R7
    bus_order_chk: assert property (@(posedge clk) disable iff (rst)
        (as_want && md_want) |=> (wb_valid && wb_idx == $past(md_cidx)));

    // R4
    tag_pending_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> pend_q[wb_tag]);

    // R1
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> (iss_idx == $past(iss_idx) + IDX_W'(1)));

endmodule

// File: tb/sim_tomasulo_sched.sv
module sim_tomasulo_sched;
    import sched_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 12;
    localparam int MAIN_N = 10;
    localparam int RUN_CYC = 40;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] dst;
        logic [3:0] sa;
        logic [3:0] sb;
        logic [7:0] ci;
        logic [7:0] cs;
        logic [7:0] cw;
    } row_t;

    // op dst srcA srcB | issue start writeback
    localparam row_t MAIN_TBL [MAIN_N] = '{
        '{2'd2, 4'd1,  4'd0, 4'd0, 8'd1,  8'd2,  8'd5},
        '{2'd3, 4'd2,  4'd1, 4'd0, 8'd2,  8'd6,  8'd13},
        '{2'd0, 4'd3,  4'd1, 4'd0, 8'd3,  8'd6,  8'd7},
        '{2'd1, 4'd4,  4'd3, 4'd0, 8'd4,  8'd8,  8'd9},
        '{2'd3, 4'd5,  4'd0, 4'd0, 8'd6,  8'd14, 8'd21},
        '{2'd0, 4'd6,  4'd2, 4'd0, 8'd7,  8'd14, 8'd15},
        '{2'd1, 4'd7,  4'd5, 4'd0, 8'd8,  8'd22, 8'd23},
        '{2'd2, 4'd8,  4'd0, 4'd0, 8'd14, 8'd22, 8'd26},
        '{2'd0, 4'd9,  4'd7, 4'd0, 8'd15, 8'd24, 8'd25},
        '{2'd1, 4'd10, 4'd0, 4'd0, 8'd16, 8'd17, 8'd18}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       in_op = '0;
    logic [TAG_W-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic             in_ready, iss_valid, as_start, md_start, wb_valid;
    logic [IDX_W-1:0] iss_idx, as_start_idx, md_start_idx, wb_idx;
    logic [TAG_W-1:0] wb_tag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;
    row_t prog [MAXN];
    int nprog;
    int got_i [MAXN+1];
    int got_s [MAXN+1];
    int got_w [MAXN+1];
    int got_t [MAXN+1];

    always #(CLK_PERIOD/2) clk = ~clk;

    tomasulo_sched u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_ready(in_ready), .iss_valid(iss_valid), .iss_idx(iss_idx),
        .as_start(as_start), .as_start_idx(as_start_idx),
        .md_start(md_start), .md_start_idx(md_start_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_tag(wb_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 5000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc_total);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic drive_head(input int head);
        if (head < nprog) begin
            in_valid = 1'b1;
            in_op    = prog[head].op;
            in_dst   = prog[head].dst;
            in_src_a = prog[head].sa;
            in_src_b = prog[head].sb;
        end else begin
            in_valid = 1'b0;
        end
    endtask

    task automatic run_prog();
        int head;
        int cyc;
        for (int k = 0; k <= MAXN; k++) begin
            got_i[k] = -1; got_s[k] = -1; got_w[k] = -1; got_t[k] = -1;
        end
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R9: reset state seen at the ports
        chk(in_ready && !wb_valid && !as_start && !md_start && iss_idx == 8'd1,
            "R9 reset state", {in_ready, wb_valid, as_start, md_start}, 4'b1000);
        @(posedge clk);
        #1 rst = 1'b0;
        head = 0;
        cyc = 1;
        drive_head(head);
        for (int c = 0; c < RUN_CYC; c++) begin
            @(negedge clk);
            if (iss_valid && int'(iss_idx) <= MAXN) begin
                got_i[iss_idx] = cyc;
                head++;
            end
            if (as_start && int'(as_start_idx) <= MAXN) got_s[as_start_idx] = cyc;
            if (md_start && int'(md_start_idx) <= MAXN) got_s[md_start_idx] = cyc;
            if (wb_valid && int'(wb_idx) <= MAXN) begin
                got_w[wb_idx] = cyc;
                got_t[wb_idx] = int'(wb_tag);
            end
            @(posedge clk);
            #1;
            cyc++;
            drive_head(head);
        end
        for (int k = 0; k < nprog; k++) begin
            chk(got_i[k+1] == int'(prog[k].ci), $sformatf("R1 issue cycle of #%0d", k+1), got_i[k+1], int'(prog[k].ci));
            chk(got_s[k+1] == int'(prog[k].cs), $sformatf("R4 start cycle of #%0d", k+1), got_s[k+1], int'(prog[k].cs));
            chk(got_w[k+1] == int'(prog[k].cw), $sformatf("R5 writeback cycle of #%0d", k+1), got_w[k+1], int'(prog[k].cw));
            chk(got_t[k+1] == int'(prog[k].dst), $sformatf("R10 writeback tag of #%0d", k+1), got_t[k+1], int'(prog[k].dst));
            chk(got_s[k+1] > got_i[k+1], $sformatf("R3 start after issue of #%0d", k+1), got_s[k+1], got_i[k+1] + 1);
        end
    endtask

    initial begin
        // main table walk: mixed program with stalls and a bus tie
        nprog = MAIN_N;
        for (int k = 0; k < MAIN_N; k++) prog[k] = MAIN_TBL[k];
        run_prog();
        chk(got_i[5] == got_w[1] + 1, "R2 reissue after slot release", got_i[5], got_w[1] + 1);
        chk(got_s[2] == got_s[3], "R6 units start together", got_s[3], got_s[2]);
        chk(got_w[8] == got_w[9] + 1, "R7 mul/div deferred behind add/sub", got_w[8], got_w[9] + 1);

        // directed: same-cycle wakeup at issue and oldest-first selection
        nprog = 3;
        prog[0] = '{2'd0, 4'd1, 4'd0, 4'd0, 8'd1, 8'd2, 8'd3};
        prog[1] = '{2'd0, 4'd2, 4'd1, 4'd0, 8'd2, 8'd4, 8'd5};
        prog[2] = '{2'd1, 4'd3, 4'd1, 4'd0, 8'd3, 8'd6, 8'd7};
        run_prog();
        chk(got_s[2] < got_s[3], "R8 older ready slot starts first", got_s[2], got_s[3] - 2);

        // directed: mul/div pool full, in-order stall, delayed broadcast keeps unit
        nprog = 4;
        prog[0] = '{2'd2, 4'd1, 4'd0, 4'd0, 8'd1, 8'd2,  8'd5};
        prog[1] = '{2'd2, 4'd2, 4'd0, 4'd0, 8'd2, 8'd6,  8'd10};
        prog[2] = '{2'd3, 4'd3, 4'd0, 4'd0, 8'd6, 8'd11, 8'd18};
        prog[3] = '{2'd0, 4'd4, 4'd0, 4'd0, 8'd7, 8'd8,  8'd9};
        run_prog();
        chk(got_s[3] == got_w[2] + 1, "R7 unit held until delayed broadcast", got_s[3], got_w[2] + 1);
        chk(got_i[4] == got_i[3] + 1, "R1 younger add waits behind stalled divide", got_i[4], got_i[3] + 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule